// File: doc/BRIEF.md
# Serial-Wire Connection Sequencer

This block brings a debug port out of JTAG and into serial-wire operation. On a start pulse it takes over the debug clock and data lines. It clocks out the fixed switch pattern and follows it with an idle byte. It then releases the lines and asks the transaction engine for the identification-register read that enables the link. When the engine reports the result of that read, the block emits a single done pulse. A link flag goes with the pulse and is set only for a clean response.

The debug clock runs from the system clock. Each half period of the debug clock lasts `clk_div + 1` system cycles. The data line changes only while the debug clock is low, so the target samples stable data on every rising edge. The sequence runs in full every time, whether or not the port was already in serial-wire mode.

Top module: `swd_switch_seq`

## Requirements
- R1: While reset is asserted and at rest, `swclk_o` is 1, `swdio_oe` is 0, and `req_valid` and `done` are 0. A reset in mid-sequence returns the lines to this state.
- R2: After a `start` pulse, exactly 152 rising edges of `swclk_o` are produced with `swdio_oe` at 1. `swdio_o` never changes while `swclk_o` is high.
- R3: The values of `swdio_o` at rising edges 0 to 63 are all 1.
- R4: The values at rising edges 64 to 79 are the 16-bit word 0xE79E, least significant bit first. Edge 64 carries bit 0.
- R5: The values at rising edges 80 to 143 are all 1.
- R6: The values at rising edges 144 to 151 are all 0.
- R7: During the pattern, each low phase and each high phase of `swclk_o` lasts exactly `clk_div + 1` system cycles.
- R8: After the last rising edge, `swdio_oe` drops to 0 and `swclk_o` stays at 1. Then `req_valid` rises with `req_cmd` = 0xA5 and stays high until a cycle in which `req_ready` is 1.
- R9: The cycle after `rsp_valid` is sampled while the block waits for the read result, `done` is 1 for exactly one cycle. `link_ok` is 1 in that cycle only if `rsp_ack` is 3'b001 (the OK code; bit 0 is the first acknowledge bit received) and `rsp_parity_err` is 0. Otherwise `link_ok` is 0.
- R10: A `start` pulse that arrives while a sequence is in progress has no effect: the pattern keeps its 152 edges and its content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the connection sequence |
| clk_div | input | DIV_W | Half-period length of the debug clock minus one, in system cycles |
| swclk_o | output | 1 | Debug clock line drive |
| swdio_o | output | 1 | Debug data line value |
| swdio_oe | output | 1 | Debug data line output enable |
| req_valid | output | 1 | Request to the transaction engine |
| req_ready | input | 1 | Transaction engine accepts the request |
| req_cmd | output | 8 | Command byte for the identification read |
| rsp_valid | input | 1 | Transaction engine result available |
| rsp_ack | input | 3 | Acknowledge code received by the engine |
| rsp_parity_err | input | 1 | Data parity error reported by the engine |
| done | output | 1 | One-cycle end-of-sequence pulse |
| link_ok | output | 1 | Connection succeeded, valid with `done` |

## Verification
The boundaries between the pattern's four segments are the hardest part to observe. Errors at those boundaries show up only in a single bit out of 152, and only at the rising edge. The bench therefore records the data value at every rising edge of the debug clock and checks each segment on its own against a pattern it builds itself. It repeats this at several divider settings, so that phase-length errors separate from content errors. A second start pulse in mid-pattern and a reset in mid-pattern are injected, and the recorded edge count shows whether either one disturbed the run.

// File: rtl/swd_sw_pkg.sv
package swd_sw_pkg;
  typedef enum logic [2:0] {
    ST_REST,
    ST_LOW,
    ST_HIGH,
    ST_REQ,
    ST_WAIT
  } seq_state_t;

  localparam int unsigned PRE_ONES  = 64;
  localparam int unsigned KEY_W     = 16;
  localparam logic [15:0] KEY_WORD  = 16'hE79E;
  localparam int unsigned POST_ONES = 64;
  localparam int unsigned IDLE_LEN  = 8;
  localparam logic [7:0]  ID_CMD    = 8'hA5;
  localparam logic [2:0]  ACK_GOOD  = 3'b001;
endpackage

// File: rtl/swd_sw_halfbit_timer.sv
module swd_sw_halfbit_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] div,
  output logic             expire
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= div;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/swd_sw_pattern_gen.sv
module swd_sw_pattern_gen #(
  parameter int unsigned PRE_N  = 64,
  parameter int unsigned KEY_N  = 16,
  parameter logic [KEY_N-1:0] KEY = '1,
  parameter int unsigned POST_N = 64,
  parameter int unsigned IDLE_N = 8,
  localparam int unsigned TOTAL = PRE_N + KEY_N + POST_N + IDLE_N,
  localparam int unsigned IDX_W = $clog2(TOTAL + 1)
) (
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  localparam int unsigned KEY_END  = PRE_N + KEY_N;
  localparam int unsigned POST_END = KEY_END + POST_N;
  localparam int unsigned KSEL_W   = (KEY_N > 1) ? $clog2(KEY_N) : 1;

  logic [KSEL_W-1:0] key_sel;
  logic [IDX_W-1:0]  key_off;

  always_comb begin
    key_off = idx - IDX_W'(PRE_N);
    key_sel = key_off[KSEL_W-1:0];
    if (idx < IDX_W'(PRE_N))         bit_o = 1'b1;
    else if (idx < IDX_W'(KEY_END))  bit_o = KEY[key_sel];
    else if (idx < IDX_W'(POST_END)) bit_o = 1'b1;
    else                             bit_o = 1'b0;
  end
endmodule

// File: rtl/swd_sw_rsp_eval.sv
module swd_sw_rsp_eval #(
  parameter logic [2:0] GOOD = 3'b001
) (
  input  logic [2:0] ack,
  input  logic       parity_err,
  output logic       ok
);
  always_comb ok = (ack == GOOD) && !parity_err;
endmodule

// File: rtl/swd_switch_seq.sv
module swd_switch_seq
  import swd_sw_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] clk_div,
  output logic             swclk_o,
  output logic             swdio_o,
  output logic             swdio_oe,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [7:0]       req_cmd,
  input  logic             rsp_valid,
  input  logic [2:0]       rsp_ack,
  input  logic             rsp_parity_err,
  output logic             done,
  output logic             link_ok
);
  localparam int unsigned TOTAL = PRE_ONES + KEY_W + POST_ONES + IDLE_LEN;
  localparam int unsigned IDX_W = $clog2(TOTAL + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] nxt_idx;
  logic             nxt_bit;
  logic             tmr_load;
  logic             tmr_exp;
  logic             rsp_ok;

  assign nxt_idx  = (state == ST_REST) ? '0 : idx + 1'b1;
  assign tmr_load = ((state == ST_REST) && start) ||
                    (((state == ST_LOW) || (state == ST_HIGH)) && tmr_exp);
  assign req_cmd  = ID_CMD;

  swd_sw_halfbit_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .div(clk_div), .expire(tmr_exp)
  );

  swd_sw_pattern_gen #(
    .PRE_N(PRE_ONES), .KEY_N(KEY_W), .KEY(KEY_WORD),
    .POST_N(POST_ONES), .IDLE_N(IDLE_LEN)
  ) u_pat (
    .idx(nxt_idx), .bit_o(nxt_bit)
  );

  swd_sw_rsp_eval #(.GOOD(ACK_GOOD)) u_eval (
    .ack(rsp_ack), .parity_err(rsp_parity_err), .ok(rsp_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_REST;
      idx       <= '0;
      swclk_o   <= 1'b1;
      swdio_o   <= 1'b0;
      swdio_oe  <= 1'b0;
      req_valid <= 1'b0;
      done      <= 1'b0;
      link_ok   <= 1'b0;
    end else begin
      done    <= 1'b0;
      link_ok <= 1'b0;
      case (state)
        ST_REST: begin
          if (start) begin
            state    <= ST_LOW;
            idx      <= '0;
            swclk_o  <= 1'b0;
            swdio_o  <= nxt_bit;
            swdio_oe <= 1'b1;
          end
        end
        ST_LOW: begin
          if (tmr_exp) begin
            state   <= ST_HIGH;
            swclk_o <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (tmr_exp) begin
            if (idx == LAST) begin
              state     <= ST_REQ;
              swdio_oe  <= 1'b0;
              swdio_o   <= 1'b0;
              req_valid <= 1'b1;
            end else begin
              state   <= ST_LOW;
              idx     <= nxt_idx;
              swclk_o <= 1'b0;
              swdio_o <= nxt_bit;
            end
          end
        end
        ST_REQ: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            done    <= 1'b1;
            link_ok <= rsp_ok;
            state   <= ST_REST;
          end
        end
        default: state <= ST_REST;
      endcase
    end
  end
endmodule

// File: rtl/swd_switch_seq_chk.sv
module swd_switch_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       swclk_o,
  input logic       swdio_o,
  input logic       swdio_oe,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [2:0] rsp_ack,
  input logic       rsp_parity_err,
  input logic       done,
  input logic       link_ok
);
  assert_rest_clk_high_R1: assert property (@(posedge clk) disable iff (rst)
    !swdio_oe |-> swclk_o);

  assert_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (swclk_o && $past(swclk_o) && swdio_oe && $past(swdio_oe)) |-> (swdio_o == $past(swdio_o)));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid);

  assert_req_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !swdio_oe);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rsp_valid));

  assert_ok_only_good_R9: assert property (@(posedge clk) disable iff (rst)
    (done && link_ok) |-> $past(rsp_ack == 3'b001 && !rsp_parity_err));

  assert_ok_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    link_ok |-> done);
endmodule

bind swd_switch_seq swd_switch_seq_chk u_chk (
  .clk(clk), .rst(rst), .swclk_o(swclk_o), .swdio_o(swdio_o), .swdio_oe(swdio_oe),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ack(rsp_ack), .rsp_parity_err(rsp_parity_err), .done(done), .link_ok(link_ok)
);

// File: tb/swd_switch_seq_tb.sv
module swd_switch_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] clk_div = 8'd0;
  logic       swclk_o, swdio_o, swdio_oe, req_valid, done, link_ok;
  logic       req_ready = 1'b0;
  logic [7:0] req_cmd;
  logic       rsp_valid = 1'b0;
  logic [2:0] rsp_ack = 3'b000;
  logic       rsp_parity_err = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  swd_switch_seq #(.DIV_W(8)) u_dut (
    .clk(clk), .rst(rst), .start(start), .clk_div(clk_div),
    .swclk_o(swclk_o), .swdio_o(swdio_o), .swdio_oe(swdio_oe),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_parity_err(rsp_parity_err),
    .done(done), .link_ok(link_ok)
  );

  // expected pattern built from the requirements
  logic [151:0] exp_pat;
  initial begin
    for (int i = 0; i < 152; i++) begin
      if (i < 64)       exp_pat[i] = 1'b1;
      else if (i < 80)  exp_pat[i] = 16'hE79E >> (i - 64);
      else if (i < 144) exp_pat[i] = 1'b1;
      else              exp_pat[i] = 1'b0;
    end
  end

  // line monitor
  logic [151:0] cap;
  int  rise_cnt, run_len, phase_err, stab_err;
  logic prev_clk, prev_dio, prev_oe;
  logic mon_clr = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      cap = '0; rise_cnt = 0; run_len = 0; phase_err = 0; stab_err = 0;
    end else begin
      if (swdio_oe && !prev_oe) run_len = 1;
      else if (swdio_oe && prev_oe) begin
        if (swclk_o == prev_clk) run_len++;
        else begin
          if (run_len != int'(clk_div) + 1) phase_err++;
          run_len = 1;
        end
        if (swclk_o && prev_clk && swdio_o != prev_dio) stab_err++;
      end
      if (swdio_oe && swclk_o && !prev_clk) begin
        if (rise_cnt < 152) cap[rise_cnt] = swdio_o;
        rise_cnt++;
      end
    end
    prev_clk = swclk_o; prev_dio = swdio_o; prev_oe = swdio_oe;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // one full connection; extra_start injects a start mid-pattern
  task automatic run_seq(input logic [7:0] div, input logic [2:0] ack, input logic par,
                         input logic exp_ok, input logic extra_start);
    int guard;
    clk_div = div;
    clear_mon();
    pulse_start();
    if (extra_start) begin
      repeat (100) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (!req_valid && guard < 5000) begin @(negedge clk); guard++; end
    check("R2 edge count", 64'(rise_cnt), 64'd152);
    check("R2 data stable while clock high", 64'(stab_err), 64'd0);
    check("R3 leading ones", 64'(cap[63:0]), exp_pat[63:0]);
    check("R4 key word", 64'(cap[79:64]), 64'(exp_pat[79:64]));
    check("R5 trailing ones", 64'(cap[143:80]), exp_pat[143:80]);
    check("R6 idle zeros", 64'(cap[151:144]), 64'(exp_pat[151:144]));
    check("R7 phase length", 64'(phase_err), 64'd0);
    check("R8 lines released", {62'd0, swclk_o, swdio_oe}, 64'b10);
    check("R8 command", 64'(req_cmd), 64'hA5);
    repeat (3) @(negedge clk);
    check("R8 request held", 64'(req_valid), 64'd1);
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    check("R8 request dropped", 64'(req_valid), 64'd0);
    repeat (2) @(negedge clk);
    check("R9 no early done", 64'(done), 64'd0);
    rsp_valid = 1'b1; rsp_ack = ack; rsp_parity_err = par;
    @(negedge clk);
    rsp_valid = 1'b0;
    check("R9 done", {62'd0, done, link_ok}, {62'd0, 1'b1, exp_ok});
    @(negedge clk);
    check("R9 done single cycle", 64'(done), 64'd0);
  endtask

  // div, ack, parity_err, expected link_ok, extra start
  localparam logic [13:0] VEC [6] = '{
    {8'd0, 3'b001, 1'b0, 1'b1, 1'b0},
    {8'd2, 3'b001, 1'b1, 1'b0, 1'b0},
    {8'd1, 3'b010, 1'b0, 1'b0, 1'b1},
    {8'd3, 3'b100, 1'b0, 1'b0, 1'b0},
    {8'd0, 3'b111, 1'b0, 1'b0, 1'b0},
    {8'd1, 3'b001, 1'b0, 1'b1, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset lines", {60'd0, swclk_o, swdio_oe, req_valid, done}, 64'b1000);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 rest lines", {60'd0, swclk_o, swdio_oe, req_valid, done}, 64'b1000);

    for (int v = 0; v < 6; v++) begin
      logic [13:0] e;
      e = VEC[v];
      run_seq(e[13:6], e[5:3], e[2], e[1], e[0]);
      if (e[0]) check("R10 start ignored while busy", 64'(rise_cnt), 64'd152);
    end

    // response while at rest produces nothing
    rsp_valid = 1'b1; rsp_ack = 3'b001; @(negedge clk); rsp_valid = 1'b0;
    @(negedge clk);
    check("R9 response at rest ignored", 64'(done), 64'd0);

    // reset in mid-pattern
    clk_div = 8'd0;
    pulse_start();
    repeat (40) @(negedge clk);
    rst = 1'b1; @(negedge clk); @(negedge clk);
    check("R1 mid-pattern reset", {61'd0, swclk_o, swdio_oe, req_valid}, 64'b100);
    rst = 1'b0;
    @(negedge clk);
    run_seq(8'd0, 3'b001, 1'b0, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule